// File: doc/BRIEF.md
# Configurable ADC Serial Output Formatter

This block takes parallel samples from one data converter channel and sends each one out as a word on a single serial data line. Alongside the data it drives a bit clock and a frame clock. The logic runs on a slot clock. In double data rate mode one serial bit lasts one slot, so the bit clock changes level on every slot. In single data rate mode one bit lasts two slots, so the bit clock makes one full period per bit.

A format register sets the word length, the clock mode, the bit order, the number format and the position of the bit clock edge in single data rate mode. A master enable bit in that register gates these fields. A second, small register selects an alternating training pattern, which receivers use to deskew their sampling point.

The sample and all settings are taken at the start of each word. Writes made while a word is on the line do not affect that word, so every word goes out entirely in one format.

Top module: `adc_serial_formatter`

## Requirements
- R1: While `rst_n` is low, `ser_data`, `bit_clk` and `frame_clk` are 0 and both registers clear to 0. The first word starts in the slot after the first clock edge that sees `rst_n` high.
- R2: The write port has two addresses. `wr_addr`=0 is the format register and `wr_addr`=1 is the pattern register. In the format register, bit 15 is the master enable. While bit 15 is 0, bits 13, 11:8, 4, 3 and 2 have no effect. The block then sends 12-bit words (or the last legal length) in double data rate, LSB first, offset binary.
- R3: With the master enable set, format bits 11:8 select the word length. Code 0001 gives 10 bits, 0010 gives 12 bits and 0100 gives 14 bits. The frame period is the word length in slots for double data rate and twice that for single data rate.
- R4: Any other length code, or a length code written with the enable at 0, leaves the word length unchanged. After reset the length is 12 bits.
- R5: Format bit 4 = 0 selects double data rate. One bit is sent per slot, and `bit_clk` is 1 in the first slot of a word and inverts in every following slot.
- R6: Format bit 4 = 1 selects single data rate. Each bit lasts two slots. With format bit 13 = 0, `bit_clk` is 1 in the first slot of each bit and 0 in the second, so it rises at the bit boundary. With bit 13 = 1, it is 0 then 1, so it rises at the bit centre.
- R7: Format bit 3 = 0 sends the sample's bit 0 first. Format bit 3 = 1 sends bit L-1 first, where L is the word length. Samples are right-aligned: only bits L-1:0 of `smp_data` are sent.
- R8: Format bit 2 = 1 inverts sample bit L-1 before it is sent (two's complement). Format bit 2 = 0 sends the sample unchanged (offset binary).
- R9: When pattern register bit 0 = 1 and bit 1 = 0, each word is the alternating sequence 1,0,1,0,... starting with 1, in place of sample data. With bit 1 = 1, bit 0 has no effect.
- R10: `frame_clk` is 1 for the first half of a word's slots and 0 for the second half. It rises in the slot that carries the word's first bit.
- R11: `smp_data` and both registers are sampled on the clock edge that starts a word. Changes between word starts affect only the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = format register, 1 = pattern register |
| wr_data | input | 16 | Register write data |
| smp_data | input | 14 | Parallel sample, right-aligned |
| ser_data | output | 1 | Serial data line |
| bit_clk | output | 1 | Bit clock |
| frame_clk | output | 1 | Frame clock |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before it is released. They also assume that nothing outside the write port changes the active word's settings: they rely on the shift engine taking the settings only at a word start. No condition is placed on when writes or sample changes arrive. The stimulus therefore writes registers at arbitrary slots, including in the middle of a word, and changes `smp_data` on every slot. This tests that late changes never leak into a word already on the line. Illegal length codes and gated fields are written as ordinary data, because the block must tolerate them.

// File: rtl/fmt_pkg.sv
// Package for the serial output formatter.
// Holds the widths, the register bit positions, the word-length codes and
// the resolved-configuration record shared by the formatter modules.
// Assumes the maximum word length equals the sample width.
package fmt_pkg;
    parameter int SMP_W   = 14;                  // sample width, also longest word
    parameter int CFG_W   = 16;                  // register width
    parameter int LEN_W   = 3;                   // one-hot length code width
    parameter int SLOT_W  = $clog2(2 * SMP_W);   // slot counter width

    // Format register bit positions
    parameter int B_ENABLE = 15;
    parameter int B_MID    = 13;
    parameter int B_LEN_HI = 11;
    parameter int B_LEN_LO = 8;
    parameter int B_SDR    = 4;
    parameter int B_MSB    = 3;
    parameter int B_TWOS   = 2;

    // Pattern register bit positions
    parameter int B_DESKEW = 0;
    parameter int B_ALTPAT = 1;

    typedef enum logic [LEN_W-1:0] {
        LEN10 = 3'b001,
        LEN12 = 3'b010,
        LEN14 = 3'b100
    } len_code_t;

    typedef struct packed {
        len_code_t len;
        logic      sdr;
        logic      mid;
        logic      msb;
        logic      twos;
        logic      deskew;
    } fmt_cfg_t;

    parameter fmt_cfg_t CFG_RESET = '{len: LEN12, default: 1'b0};

    // Number of serial bits in a word for a length code
    function automatic int len_bits(len_code_t c);
        case (c)
            LEN10:   return 10;
            LEN14:   return 14;
            default: return 12;
        endcase
    endfunction

    // True for the three accepted one-hot length codes
    function automatic logic len_legal(logic [B_LEN_HI-B_LEN_LO:0] c);
        return (c == 4'b0001) || (c == 4'b0010) || (c == 4'b0100);
    endfunction
endpackage

// File: rtl/fmt_ctrl_regs.sv
// Control registers of the serial output formatter.
// Stores the format fields and the pattern bits written through the
// parallel port. Applies the master-enable gating and keeps the last
// legal word length. Assumes one write per clock at most.
module fmt_ctrl_regs
    import fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CFG_W-1:0] wr_data,
    output fmt_cfg_t         cfg_eff,
    output len_code_t        len_held
);
    localparam int LCW = B_LEN_HI - B_LEN_LO + 1;

    logic      en_q, mid_q, sdr_q, msb_q, twos_q;
    logic      dsk_q, alt_q;
    len_code_t len_q;
    logic [LCW-1:0] len_wr;
    logic unused_wr_bits;

    assign len_wr = wr_data[B_LEN_HI:B_LEN_LO];
    assign unused_wr_bits = ^{wr_data[14], wr_data[12], wr_data[7:5], len_wr[LCW-1]};

    // Register update: format fields, pattern bits, held legal length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mid_q  <= 1'b0;
            sdr_q  <= 1'b0;
            msb_q  <= 1'b0;
            twos_q <= 1'b0;
            dsk_q  <= 1'b0;
            alt_q  <= 1'b0;
            len_q  <= LEN12;
        end else if (wr_en) begin
            if (!wr_addr) begin
                en_q   <= wr_data[B_ENABLE];
                mid_q  <= wr_data[B_MID];
                sdr_q  <= wr_data[B_SDR];
                msb_q  <= wr_data[B_MSB];
                twos_q <= wr_data[B_TWOS];
                if (wr_data[B_ENABLE] && len_legal(len_wr))
                    len_q <= len_code_t'(len_wr[LEN_W-1:0]);
            end else begin
                dsk_q <= wr_data[B_DESKEW];
                alt_q <= wr_data[B_ALTPAT];
            end
        end
    end

    // Gating: fields count only with the master enable set
    always_comb begin
        cfg_eff.len    = len_q;
        cfg_eff.sdr    = en_q & sdr_q;
        cfg_eff.mid    = en_q & mid_q;
        cfg_eff.msb    = en_q & msb_q;
        cfg_eff.twos   = en_q & twos_q;
        cfg_eff.deskew = dsk_q & ~alt_q;
    end

    assign len_held = len_q;
endmodule

// File: rtl/fmt_word_prep.sv
// Word preparation for the serial output formatter.
// Builds the next word from the sample and the configuration, with the
// first bit to send at the top. Applies the number format, the bit order
// and the deskew pattern. Purely combinational. Assumes a right-aligned
// sample.
module fmt_word_prep
    import fmt_pkg::*;
(
    input  logic [SMP_W-1:0] smp,
    input  fmt_cfg_t         cfg,
    output logic [SMP_W-1:0] word
);
    logic [SMP_W-1:0] field;
    int               nb;

    // Format conversion and ordering of the active field
    always_comb begin
        nb    = len_bits(cfg.len);
        field = '0;
        for (int i = 0; i < SMP_W; i++) begin
            if (i < nb)
                field[i] = smp[i];
            if (cfg.twos && (i == nb - 1))
                field[i] = ~smp[i];
        end
        word = '0;
        if (cfg.deskew) begin
            for (int i = 0; i < SMP_W; i++)
                if (i < nb)
                    word[SMP_W-1-i] = ((i % 2) == 0);
        end else if (cfg.msb) begin
            word = field << (SMP_W - nb);
        end else begin
            for (int i = 0; i < SMP_W; i++)
                if (i < nb)
                    word[SMP_W-1-i] = field[i];
        end
    end
endmodule

// File: rtl/fmt_shift_engine.sv
// Shift engine of the serial output formatter.
// Counts slots inside a word. Loads a new word and configuration at each
// word start, shifts once per serial bit, and derives the bit clock and
// the frame clock from the slot count. Outputs stay low until the first
// word. Assumes a prepared word with the first bit at the top.
module fmt_shift_engine
    import fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_cfg_t          cfg_next,
    input  logic [SMP_W-1:0]  word_next,
    output logic              ser_data,
    output logic              bit_clk,
    output logic              frame_clk,
    output logic              run,
    output logic [SLOT_W-1:0] slot,
    output fmt_cfg_t          act_cfg
);
    logic [SLOT_W-1:0] slot_q, last_slot, half_slots;
    logic [SMP_W-1:0]  sh_q;
    fmt_cfg_t          act_q;
    logic              run_q, load, bit_end;
    int                nb, total;

    // Word geometry of the active configuration
    always_comb begin
        nb         = len_bits(act_q.len);
        total      = act_q.sdr ? 2 * nb : nb;
        last_slot  = SLOT_W'(total - 1);
        half_slots = SLOT_W'(total / 2);
        load       = !run_q || (slot_q == last_slot);
        bit_end    = !act_q.sdr || slot_q[0];
    end

    // Slot counter, word load and per-bit shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            slot_q <= '0;
            act_q  <= CFG_RESET;
            sh_q   <= '0;
        end else if (load) begin
            run_q  <= 1'b1;
            slot_q <= '0;
            act_q  <= cfg_next;
            sh_q   <= word_next;
        end else begin
            slot_q <= slot_q + 1'b1;
            if (bit_end)
                sh_q <= sh_q << 1;
        end
    end

    // Line outputs derived from the registered state only
    always_comb begin
        ser_data  = run_q & sh_q[SMP_W-1];
        bit_clk   = run_q & ((act_q.sdr && act_q.mid) ? slot_q[0] : ~slot_q[0]);
        frame_clk = run_q & (slot_q < half_slots);
    end

    assign run     = run_q;
    assign slot    = slot_q;
    assign act_cfg = act_q;
endmodule

// File: rtl/adc_serial_formatter.sv
// Top of the serial output formatter.
// Connects the control registers, the word preparation and the shift
// engine. Assumes the sample input is held valid on every clock, because
// it is captured only at word starts.
module adc_serial_formatter
    import fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [SMP_W-1:0] smp_data,
    output logic             ser_data,
    output logic             bit_clk,
    output logic             frame_clk
);
    fmt_cfg_t          cfg_eff, act_cfg;
    len_code_t         len_held;
    logic [SMP_W-1:0]  word_next;
    logic              run;
    logic [SLOT_W-1:0] slot;

    fmt_ctrl_regs i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg_eff  (cfg_eff),
        .len_held (len_held)
    );

    fmt_word_prep i_prep (
        .smp  (smp_data),
        .cfg  (cfg_eff),
        .word (word_next)
    );

    fmt_shift_engine i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_next  (cfg_eff),
        .word_next (word_next),
        .ser_data  (ser_data),
        .bit_clk   (bit_clk),
        .frame_clk (frame_clk),
        .run       (run),
        .slot      (slot),
        .act_cfg   (act_cfg)
    );
endmodule

// File: rtl/fmt_checker.sv
// Assertion checker for the serial output formatter, bound to the top.
// Watches the line outputs, the slot counter, the active configuration
// and the held length. Assumes reset is asserted at the first clock edge.
module fmt_checker
    import fmt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ser_data,
    input logic              bit_clk,
    input logic              frame_clk,
    input logic              run,
    input logic [SLOT_W-1:0] slot,
    input fmt_cfg_t          act_cfg,
    input len_code_t         len_held
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!ser_data && !bit_clk && !frame_clk));

    a_r4_len_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(len_held) == 1);

    a_r3_active_len_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ($countones(act_cfg.len) == 1));

    a_r5_ddr_clk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !act_cfg.sdr && slot != 0) |-> (bit_clk != $past(bit_clk)));

    a_r6_sdr_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_cfg.sdr && slot[0]) |-> $stable(ser_data));

    a_r10_frame_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_clk) |-> (slot == 0));

    a_r10_frame_high_first: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slot == 0) |-> frame_clk);

    a_r11_cfg_held_in_word: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slot != 0) |-> $stable(act_cfg));
endmodule

bind adc_serial_formatter fmt_checker i_fmt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_data  (ser_data),
    .bit_clk   (bit_clk),
    .frame_clk (frame_clk),
    .run       (run),
    .slot      (slot),
    .act_cfg   (act_cfg),
    .len_held  (len_held)
);

// File: tb/test_adc_serial_formatter.sv
// Testbench: a behavioural reference model built on queues, compared with
// the outputs on every slot, plus direct frame-period measurements.
module test_adc_serial_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [13:0] smp_data = '0;
    logic        ser_data, bit_clk, frame_clk;

    int    total_chk = 0;
    int    bad_chk = 0;
    string cur_req = "R1";
    bit    finished = 0;

    always #5 clk = ~clk;

    adc_serial_formatter i_adc_serial_formatter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .smp_data(smp_data),
        .ser_data(ser_data), .bit_clk(bit_clk), .frame_clk(frame_clk)
    );

    // Reference model state
    logic [15:0] m_fmt;
    logic [1:0]  m_pat;
    int          m_len, m_slot, m_total;
    bit          m_run, m_sdr, m_mid;
    bit          m_bits[$];

    task automatic start_word();
        int val;
        bit en;
        en  = m_fmt[15];
        val = int'(smp_data) % (1 << m_len);
        if (en && m_fmt[2]) val = val ^ (1 << (m_len - 1));
        m_bits.delete();
        for (int i = 0; i < m_len; i++) begin
            if (m_pat == 2'b01)       m_bits.push_back(bit'((i % 2) == 0));
            else if (en && m_fmt[3])  m_bits.push_back(bit'((val >> (m_len - 1 - i)) & 1));
            else                      m_bits.push_back(bit'((val >> i) & 1));
        end
        m_sdr   = en && m_fmt[4];
        m_mid   = en && m_fmt[13];
        m_total = m_sdr ? 2 * m_len : m_len;
        m_slot  = 0;
        m_run   = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fmt = '0; m_pat = '0; m_len = 12; m_run = 0;
            m_slot = 0; m_total = 12; m_sdr = 0; m_mid = 0;
            m_bits.delete();
        end else begin
            if (!m_run || m_slot == m_total - 1) start_word();
            else m_slot++;
            if (wr_en) begin
                if (!wr_addr) begin
                    m_fmt = wr_data;
                    if (wr_data[15]) begin
                        case (wr_data[11:8])
                            4'b0001: m_len = 10;
                            4'b0010: m_len = 12;
                            4'b0100: m_len = 14;
                            default: ;
                        endcase
                    end
                end else begin
                    m_pat = wr_data[1:0];
                end
            end
        end
    end

    // Compare every slot, away from the active edge
    always @(negedge clk) begin
        bit es, eb, ef;
        int idx;
        if (m_run) begin
            idx = m_sdr ? m_slot / 2 : m_slot;
            es  = m_bits[idx];
            eb  = (m_sdr && m_mid) ? (m_slot % 2 == 1) : (m_slot % 2 == 0);
            ef  = m_slot < m_total / 2;
        end else begin
            es = 0; eb = 0; ef = 0;
        end
        if (!finished) begin
            total_chk++;
            if ({ser_data, bit_clk, frame_clk} !== {es, eb, ef}) begin
                bad_chk++;
                $display("FAIL %s slot %0d: actual data/bclk/fclk=%b%b%b expected=%b%b%b",
                         cur_req, m_slot, ser_data, bit_clk, frame_clk, es, eb, ef);
            end
        end
    end

    always @(negedge clk) smp_data <= 14'($urandom);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total_chk++;
        if (!ok) begin
            bad_chk++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input bit a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_rise();
        bit prev;
        prev = frame_clk;
        @(negedge clk);
        while (!(frame_clk && !prev)) begin
            prev = frame_clk;
            @(negedge clk);
        end
    endtask

    // Measure one frame: period and high time, after settling
    task automatic frame_check(input int exp, input string tag);
        int n, hi;
        bit prev;
        wait_rise();
        wait_rise();
        n = 0; hi = 0;
        do begin
            if (frame_clk) hi++;
            n++;
            prev = frame_clk;
            @(negedge clk);
        end while (!(frame_clk && !prev));
        chk(n == exp, tag, n, exp);
        chk(hi == exp / 2, "R10 high time", hi, exp / 2);
    endtask

    task automatic run_slots(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: quiet outputs in reset
        repeat (4) @(negedge clk);
        chk({ser_data, bit_clk, frame_clk} == 3'b000, "R1 reset outputs", int'({ser_data, bit_clk, frame_clk}), 0);
        rst_n = 1;
        // R4: default length 12, R5 default DDR
        cur_req = "R4";
        frame_check(12, "R4 default length");
        cur_req = "R5";
        run_slots(40);
        // R2: gated fields ignored without the enable
        cur_req = "R2";
        wr(0, 16'h241C);
        frame_check(12, "R2 gated length");
        run_slots(40);
        // R3: legal lengths
        cur_req = "R3";
        wr(0, 16'h8100); frame_check(10, "R3 10 bit");
        wr(0, 16'h8400); frame_check(14, "R3 14 bit");
        wr(0, 16'h8200); frame_check(12, "R3 12 bit");
        // R4: illegal codes keep the last legal length
        cur_req = "R4";
        wr(0, 16'h8300); frame_check(12, "R4 illegal 0011");
        wr(0, 16'h8400); frame_check(14, "R4 set 14");
        wr(0, 16'h8800); frame_check(14, "R4 illegal 1000");
        wr(0, 16'h8000); frame_check(14, "R4 illegal 0000");
        wr(0, 16'h0100); frame_check(14, "R4 code without enable");
        // R7: bit order
        cur_req = "R7";
        wr(0, 16'h8208); run_slots(60);
        wr(0, 16'h8100); run_slots(60);
        // R8: two's complement in both orders
        cur_req = "R8";
        wr(0, 16'h820C); run_slots(60);
        wr(0, 16'h8404); run_slots(60);
        // R6: single data rate, both edge placements
        cur_req = "R6";
        wr(0, 16'h8210); frame_check(24, "R6 SDR 12 bit");
        wr(0, 16'hA218); frame_check(24, "R6 SDR mid edge");
        wr(0, 16'hA114); frame_check(20, "R6 SDR 10 bit");
        // R9: deskew pattern, then blocked by the companion bit
        cur_req = "R9";
        wr(1, 16'h0001); run_slots(70);
        wr(0, 16'h8408); run_slots(50);
        wr(1, 16'h0003); run_slots(60);
        wr(1, 16'h0000); run_slots(20);
        // R10/R11: writes at varied slots, mid-word
        cur_req = "R11";
        for (int k = 0; k < 40; k++) begin
            logic [15:0] v;
            case (k % 6)
                0: v = 16'h8110;
                1: v = 16'hA40C;
                2: v = 16'h8208;
                3: v = 16'h2F1C;
                4: v = 16'h8714;
                default: v = 16'hA104;
            endcase
            wr(0, v);
            if (k % 5 == 0) wr(1, 16'(k % 3));
            run_slots(3 + (k * 7) % 23);
        end
        cur_req = "R10";
        wr(0, 16'h8410); frame_check(28, "R10 SDR 14 bit");
        run_slots(30);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total_chk++;
            bad_chk++;
            $display("FAIL %s: watchdog expired actual=running expected=done", cur_req);
            $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
            $finish;
        end
    end
endmodule